// File: doc/BRIEF.md
# Subordinate Processor Power-Up Sequencer

This block supervises a subordinate processor. It switches on five supply rails one after another, releases the processor's reset and then follows the processor's boot handshake phase by phase. It keeps the processor running until the processor reports completion, or until the run time is used up. Whenever it removes power, it records the reason as an 8-bit sequence-state code that software can read at any time. Each boot phase has its own seconds limit. Every cause of shutdown leaves its own code. A fault switches all rails off in a single cycle and drives reset low again.

The surrounding system supplies a one-second tick and pulses a start command together with a run-time limit, a snapshot point and a run-forever flag. It also forwards handshake strobes from the serial path: ID bytes, mode acknowledge, load complete, software up and job done. Fault strobes come in as well: emergency terminate, parity error, receive overflow and supervisor supply dropout. The block drives the rail enables, the active-low reset, the state code and a one-cycle telemetry snapshot strobe.

States, with codes and transitions:

- **Rail steps.** SQ_MAIN_ON (0x00), SQ_IO_ON (0x01), SQ_DET_ON (0x02), SQ_CORE_ON (0x03) and SQ_MPU_ON (0x04) each hold for STEP_CYCLES clocks and then pass to the next state. SQ_RST_REL (0x05) holds for STEP_CYCLES clocks and then passes to SQ_ID_RX (0x06).
- **SQ_ID_RX.** Passes to SQ_MODE_CMD (0x07) after ID_BYTES byte strobes.
- **SQ_MODE_CMD.** Passes to SQ_PROG_LOAD (0x08) on the mode acknowledge.
- **SQ_PROG_LOAD.** Passes to SQ_BOOTING (0x09) on load complete.
- **SQ_BOOTING.** Passes to SQ_RUNNING (0x0A) on software up.
- **SQ_RUNNING.** Passes to SQ_OFF_DONE (0x0C) on job done.
- **Timeouts.** A phase timeout leads to SQ_TO_ID (0x0D), SQ_TO_MODE (0x0E), SQ_TO_LOAD (0x0F), SQ_TO_BOOT (0x10) or SQ_TO_RUN (0x11), according to the phase.
- **Faults.** The fault states are SQ_OFF_ESTOP (0x13), SQ_OFF_DROP (0x14), SQ_OFF_PARITY (0x15), SQ_OFF_OVF (0x16) and SQ_OFF_UNEXP (0x17).
- **Idle and start.** SQ_IDLE (0x0B) is the state after reset and after a stop command. Every off state passes to SQ_MAIN_ON when a start command arrives.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset the state code is 0x0B, all rail enables are 0, reset_n_o is 0 and snap_o is 0.
- R2: start_i is acted on only when the state code is between 0x0B and 0x17. In those states it moves to 0x00 on the next clock and latches run_limit_i, sample_point_i and indefinite_i. In a powered state (0x00 to 0x0A) it has no effect.
- R3: Rails come on in the order main (rails_o bit 0), I/O (bit 1), detector (bit 2), core (bit 3) and MPU (bit 4), under codes 0x00 to 0x04. Each code holds for STEP_CYCLES clocks. Code 0x05 then sets reset_n_o to 1 and holds for STEP_CYCLES clocks before code 0x06.
- R4: In 0x06 the state moves to 0x07 on the ID_BYTES-th rx_byte_i strobe (58 by default) and not earlier.
- R5: In 0x07, mode_ack_i leads to 0x08. In 0x08, load_done_i leads to 0x09. In 0x09, sw_up_i leads to 0x0A. In 0x0A, done_i leads to 0x0C.
- R6: In each phase 0x06 to 0x0A, the L-th sec_tick_i counted since entering the phase leads to 0x0D, 0x0E, 0x0F, 0x10 or 0x11 respectively. L is that phase's limit, and for 0x0A it is the latched run limit.
- R7: When the latched indefinite flag is 1, ticks in 0x0A never cause a timeout.
- R8: estop_i in any powered state leads to 0x13. In an off state it has no effect.
- R9: dropout_i leads to 0x14 from any state and overrides every other input. While dropout_i stays high, start_i has no effect.
- R10: In 0x06 to 0x09, parity_err_i leads to 0x15 and rx_overflow_i leads to 0x16. If both arrive together, 0x15 wins. In 0x0A both are ignored.
- R11: An rx_byte_i strobe in 0x07 or 0x08 leads to 0x17. In 0x09 and 0x0A it has no effect.
- R12: stop_i leads to 0x0B from any state. It ranks below dropout and the boot and emergency faults, and above timeouts and progress.
- R13: In every off state, rails_o is 0 and reset_n_o is 0 from the first cycle the code is shown.
- R14: snap_o pulses for exactly one cycle when the number of ticks counted since entering 0x05 equals the latched sample point (sample point 0 fires in the first cycle of 0x05). If power is removed before that count is reached, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command strobe |
| indefinite_i | input | 1 | Run without a run timeout (latched at start) |
| run_limit_i | input | SEC_W | Run-phase limit in seconds (latched at start) |
| sample_point_i | input | SEC_W | Snapshot point in seconds after reset release (latched at start) |
| stop_i | input | 1 | Stop command strobe |
| sec_tick_i | input | 1 | One-second tick strobe |
| rx_byte_i | input | 1 | Byte received from the processor |
| mode_ack_i | input | 1 | Boot mode accepted |
| load_done_i | input | 1 | Program transfer complete |
| sw_up_i | input | 1 | Processor reports software running |
| done_i | input | 1 | Processor reports successful completion |
| estop_i | input | 1 | Emergency terminate message received |
| parity_err_i | input | 1 | Boot-message parity error |
| rx_overflow_i | input | 1 | Receive overflow during boot |
| dropout_i | input | 1 | Supervisor supply dropout |
| rails_o | output | 5 | Rail enables: main, I/O, detector, core, MPU |
| reset_n_o | output | 1 | Processor reset, active low |
| state_code_o | output | 8 | Sequence-state code |
| snap_o | output | 1 | Telemetry snapshot strobe |

## Verification
The hardest situations to reach from the ports are faults and timeouts deep in the boot handshake. Getting there takes a full rail sequence, 58 ID bytes and the earlier acknowledges. Each random iteration therefore first drives the sequencer into a randomly chosen phase through the legal handshake and only then applies a randomly chosen event there. A bench function maps each phase and event pair to the expected code, or to "stays in phase". The pairs that must be ignored include parity, overflow or stray bytes in the running phase, and run ticks with the indefinite flag set. Directed cases cover the snapshot at point zero and at a mid-phase point. They also cover a snapshot point lying beyond the run timeout, a start command during a powered phase, and parity arriving together with overflow.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NUM_RAILS = 5;

    typedef enum logic [7:0] {
        SQ_MAIN_ON    = 8'h00,
        SQ_IO_ON      = 8'h01,
        SQ_DET_ON     = 8'h02,
        SQ_CORE_ON    = 8'h03,
        SQ_MPU_ON     = 8'h04,
        SQ_RST_REL    = 8'h05,
        SQ_ID_RX      = 8'h06,
        SQ_MODE_CMD   = 8'h07,
        SQ_PROG_LOAD  = 8'h08,
        SQ_BOOTING    = 8'h09,
        SQ_RUNNING    = 8'h0A,
        SQ_IDLE       = 8'h0B,
        SQ_OFF_DONE   = 8'h0C,
        SQ_TO_ID      = 8'h0D,
        SQ_TO_MODE    = 8'h0E,
        SQ_TO_LOAD    = 8'h0F,
        SQ_TO_BOOT    = 8'h10,
        SQ_TO_RUN     = 8'h11,
        SQ_OFF_ESTOP  = 8'h13,
        SQ_OFF_DROP   = 8'h14,
        SQ_OFF_PARITY = 8'h15,
        SQ_OFF_OVF    = 8'h16,
        SQ_OFF_UNEXP  = 8'h17
    } seq_state_e;

endpackage

// File: rtl/pwrseq_counter.sv
module pwrseq_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != {W{1'b1}})) begin
            cnt_o <= cnt_o + W'(1);
        end
    end

endmodule

// File: rtl/pwrseq_snapshot.sv
module pwrseq_snapshot #(
    parameter int SEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] target_i,
    output logic             strobe_o
);

    logic [SEC_W-1:0] secs_q;
    logic             fired_q;

    assign strobe_o = active_i && !fired_q && (secs_q == target_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs_q  <= '0;
            fired_q <= 1'b0;
        end else if (!active_i) begin
            secs_q  <= '0;
            fired_q <= 1'b0;
        end else begin
            if (tick_i && (secs_q != {SEC_W{1'b1}})) begin
                secs_q <= secs_q + SEC_W'(1);
            end
            if (strobe_o) begin
                fired_q <= 1'b1;
            end
        end
    end

    AST_SNAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R14

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
    import pwrseq_pkg::*;
#(
    parameter int STEP_CYCLES    = 16,
    parameter int ID_BYTES       = 58,
    parameter int ID_TIMEOUT_S   = 2,
    parameter int MODE_TIMEOUT_S = 2,
    parameter int LOAD_TIMEOUT_S = 10,
    parameter int BOOT_TIMEOUT_S = 5,
    parameter int SEC_W          = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 indefinite_i,
    input  logic [SEC_W-1:0]     run_limit_i,
    input  logic [SEC_W-1:0]     sample_point_i,
    input  logic                 stop_i,
    input  logic                 sec_tick_i,
    input  logic                 rx_byte_i,
    input  logic                 mode_ack_i,
    input  logic                 load_done_i,
    input  logic                 sw_up_i,
    input  logic                 done_i,
    input  logic                 estop_i,
    input  logic                 parity_err_i,
    input  logic                 rx_overflow_i,
    input  logic                 dropout_i,
    output logic [NUM_RAILS-1:0] rails_o,
    output logic                 reset_n_o,
    output logic [7:0]           state_code_o,
    output logic                 snap_o
);

    localparam int STEP_W = $clog2(STEP_CYCLES + 1);
    localparam int BYTE_W = $clog2(ID_BYTES + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
    localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(ID_BYTES - 1);
    localparam logic [SEC_W-1:0]  LIM_ID    = SEC_W'(ID_TIMEOUT_S);
    localparam logic [SEC_W-1:0]  LIM_MODE  = SEC_W'(MODE_TIMEOUT_S);
    localparam logic [SEC_W-1:0]  LIM_LOAD  = SEC_W'(LOAD_TIMEOUT_S);
    localparam logic [SEC_W-1:0]  LIM_BOOT  = SEC_W'(BOOT_TIMEOUT_S);

    seq_state_e state_q, state_d;

    logic [STEP_W-1:0] step_cnt;
    logic [BYTE_W-1:0] byte_cnt;
    logic [SEC_W-1:0]  sec_cnt;
    logic [SEC_W-1:0]  run_lim_q;
    logic [SEC_W-1:0]  sample_q;
    logic              indef_q;

    logic powered, in_boot, phase_change, step_done, snap_active, accept_start;

    function automatic logic expired(input logic [SEC_W-1:0] cnt,
                                     input logic [SEC_W-1:0] lim);
        return ({1'b0, cnt} + (SEC_W+1)'(1)) >= {1'b0, lim};
    endfunction

    assign powered      = (state_q < SQ_IDLE);
    assign in_boot      = (state_q >= SQ_ID_RX) && (state_q <= SQ_BOOTING);
    assign phase_change = (state_d != state_q);
    assign step_done    = (step_cnt == STEP_LAST);
    assign snap_active  = (state_q >= SQ_RST_REL) && (state_q <= SQ_RUNNING);
    assign accept_start = !powered && (state_d == SQ_MAIN_ON);

    // Cycle counter for rail steps
    pwrseq_counter #(.W(STEP_W)) u_step_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_change),
        .inc_i (1'b1),
        .cnt_o (step_cnt)
    );

    // Second counter for phase timeouts
    pwrseq_counter #(.W(SEC_W)) u_sec_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_change),
        .inc_i (sec_tick_i),
        .cnt_o (sec_cnt)
    );

    // ID byte counter
    pwrseq_counter #(.W(BYTE_W)) u_byte_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_change),
        .inc_i (rx_byte_i && (state_q == SQ_ID_RX)),
        .cnt_o (byte_cnt)
    );

    pwrseq_snapshot #(.SEC_W(SEC_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (snap_active),
        .tick_i   (sec_tick_i),
        .target_i (sample_q),
        .strobe_o (snap_o)
    );

    // Next-state selection: normal flow first, then overrides in rising priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_MAIN_ON:   if (step_done) state_d = SQ_IO_ON;
            SQ_IO_ON:     if (step_done) state_d = SQ_DET_ON;
            SQ_DET_ON:    if (step_done) state_d = SQ_CORE_ON;
            SQ_CORE_ON:   if (step_done) state_d = SQ_MPU_ON;
            SQ_MPU_ON:    if (step_done) state_d = SQ_RST_REL;
            SQ_RST_REL:   if (step_done) state_d = SQ_ID_RX;
            SQ_ID_RX: begin
                if (sec_tick_i && expired(sec_cnt, LIM_ID)) state_d = SQ_TO_ID;
                else if (rx_byte_i && (byte_cnt == BYTE_LAST)) state_d = SQ_MODE_CMD;
            end
            SQ_MODE_CMD: begin
                if (sec_tick_i && expired(sec_cnt, LIM_MODE)) state_d = SQ_TO_MODE;
                else if (mode_ack_i) state_d = SQ_PROG_LOAD;
            end
            SQ_PROG_LOAD: begin
                if (sec_tick_i && expired(sec_cnt, LIM_LOAD)) state_d = SQ_TO_LOAD;
                else if (load_done_i) state_d = SQ_BOOTING;
            end
            SQ_BOOTING: begin
                if (sec_tick_i && expired(sec_cnt, LIM_BOOT)) state_d = SQ_TO_BOOT;
                else if (sw_up_i) state_d = SQ_RUNNING;
            end
            SQ_RUNNING: begin
                if (!indef_q && sec_tick_i && expired(sec_cnt, run_lim_q)) state_d = SQ_TO_RUN;
                else if (done_i) state_d = SQ_OFF_DONE;
            end
            SQ_IDLE, SQ_OFF_DONE, SQ_TO_ID, SQ_TO_MODE, SQ_TO_LOAD, SQ_TO_BOOT,
            SQ_TO_RUN, SQ_OFF_ESTOP, SQ_OFF_DROP, SQ_OFF_PARITY, SQ_OFF_OVF,
            SQ_OFF_UNEXP: begin
                if (start_i) state_d = SQ_MAIN_ON;
            end
            default: state_d = SQ_IDLE;
        endcase

        if (stop_i) state_d = SQ_IDLE;
        if (rx_byte_i && ((state_q == SQ_MODE_CMD) || (state_q == SQ_PROG_LOAD)))
            state_d = SQ_OFF_UNEXP;
        if (rx_overflow_i && in_boot) state_d = SQ_OFF_OVF;
        if (parity_err_i && in_boot)  state_d = SQ_OFF_PARITY;
        if (estop_i && powered)       state_d = SQ_OFF_ESTOP;
        if (dropout_i)                state_d = SQ_OFF_DROP;
    end

    // State register and start-time latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            run_lim_q <= '0;
            sample_q  <= '0;
            indef_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_start) begin
                run_lim_q <= run_limit_i;
                sample_q  <= sample_point_i;
                indef_q   <= indefinite_i;
            end
        end
    end

    // Moore outputs
    always_comb begin
        rails_o      = '0;
        reset_n_o    = 1'b0;
        state_code_o = state_q;
        unique case (state_q)
            SQ_MAIN_ON:  rails_o = 5'b00001;
            SQ_IO_ON:    rails_o = 5'b00011;
            SQ_DET_ON:   rails_o = 5'b00111;
            SQ_CORE_ON:  rails_o = 5'b01111;
            SQ_MPU_ON:   rails_o = 5'b11111;
            SQ_RST_REL, SQ_ID_RX, SQ_MODE_CMD, SQ_PROG_LOAD, SQ_BOOTING,
            SQ_RUNNING: begin
                rails_o   = 5'b11111;
                reset_n_o = 1'b1;
            end
            default: begin
                rails_o   = '0;
                reset_n_o = 1'b0;
            end
        endcase
    end

    AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code_o >= 8'h0B) |-> (rails_o == '0 && !reset_n_o)); // R13

    AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code_o == 8'h00 && $past(state_code_o) != 8'h00)
            |-> ($past(state_code_o) >= 8'h0B)); // R2

    AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dropout_i |=> (state_code_o == 8'h14)); // R9

    AST_ESTOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (estop_i && !dropout_i && state_code_o < 8'h0B) |=> (state_code_o == 8'h13)); // R8

    AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rails_o[4] |-> rails_o[3]); // R3

    AST_RESET_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_n_o |-> (rails_o == 5'b11111)); // R3

endmodule

// File: tb/pwr_sequencer_bench.sv
module pwr_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STEP = 3;
    localparam int IDB  = 58;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, indefinite_i = 0, stop_i = 0, sec_tick_i = 0, rx_byte_i = 0;
    logic mode_ack_i = 0, load_done_i = 0, sw_up_i = 0, done_i = 0, estop_i = 0;
    logic parity_err_i = 0, rx_overflow_i = 0, dropout_i = 0;
    logic [15:0] run_limit_i = 16'd3, sample_point_i = 16'd200;
    logic [4:0] rails_o;
    logic reset_n_o, snap_o;
    logic [7:0] state_code_o;

    int checks = 0, fails = 0, snaps = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n && snap_o) snaps++;

    pwr_sequencer #(
        .STEP_CYCLES(STEP), .ID_BYTES(IDB), .ID_TIMEOUT_S(4), .MODE_TIMEOUT_S(2),
        .LOAD_TIMEOUT_S(3), .BOOT_TIMEOUT_S(2), .SEC_W(16)
    ) u_pwr_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .indefinite_i(indefinite_i),
        .run_limit_i(run_limit_i), .sample_point_i(sample_point_i), .stop_i(stop_i),
        .sec_tick_i(sec_tick_i), .rx_byte_i(rx_byte_i), .mode_ack_i(mode_ack_i),
        .load_done_i(load_done_i), .sw_up_i(sw_up_i), .done_i(done_i), .estop_i(estop_i),
        .parity_err_i(parity_err_i), .rx_overflow_i(rx_overflow_i), .dropout_i(dropout_i),
        .rails_o(rails_o), .reset_n_o(reset_n_o), .state_code_o(state_code_o), .snap_o(snap_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 start,1 stop,2 tick,3 rx,4 mode,5 load,6 swup,7 done,8 estop,9 parity,10 ovf,11 drop,12 parity+ovf
    task automatic pulse(input int which);
        case (which)
            0: start_i = 1;  1: stop_i = 1;  2: sec_tick_i = 1;  3: rx_byte_i = 1;
            4: mode_ack_i = 1;  5: load_done_i = 1;  6: sw_up_i = 1;  7: done_i = 1;
            8: estop_i = 1;  9: parity_err_i = 1;  10: rx_overflow_i = 1;  11: dropout_i = 1;
            default: begin parity_err_i = 1; rx_overflow_i = 1; end
        endcase
        @(negedge clk);
        {start_i, stop_i, sec_tick_i, rx_byte_i, mode_ack_i, load_done_i, sw_up_i, done_i,
         estop_i, parity_err_i, rx_overflow_i, dropout_i} = '0;
    endtask

    function automatic logic [4:0] therm(input int c);
        return (c >= 4) ? 5'h1F : 5'((1 << (c + 1)) - 1);
    endfunction

    function automatic int lim_of(input int p, input int rl);
        case (p) 0: return 4; 1: return 2; 2: return 3; 3: return 2; default: return rl; endcase
    endfunction

    // phase p: 0 ID,1 mode,2 load,3 boot,4 run; kind: 0 timeout,1 estop,2 parity,3 ovf,
    // 4 stray byte,5 stop,6 dropout,7 progress
    function automatic logic [7:0] exp_code(input int p, input int kind, input bit indef);
        logic [7:0] stay = 8'(6 + p);
        case (kind)
            0: return (p == 4 && indef) ? stay : 8'(8'h0D + p);
            1: return 8'h13;
            2: return (p <= 3) ? 8'h15 : stay;
            3: return (p <= 3) ? 8'h16 : stay;
            4: return (p == 1 || p == 2) ? 8'h17 : stay;
            5: return 8'h0B;
            6: return 8'h14;
            default: return (p == 4) ? 8'h0C : 8'(8'h07 + p);
        endcase
    endfunction

    task automatic power_up();
        pulse(0);
        for (int c = 0; c <= 5; c++) begin
            chk("R3 code", state_code_o, c);
            chk("R3 rails", rails_o, therm(c));
            chk("R3 reset", reset_n_o, c == 5);
            repeat (STEP) @(negedge clk);
        end
        chk("R3 id entry", state_code_o, 8'h06);
    endtask

    task automatic goto_phase(input int p);
        power_up();
        if (p >= 1) begin
            for (int b = 0; b < IDB; b++) pulse(3);
            chk("R4 id done", state_code_o, 8'h07);
        end
        if (p >= 2) begin pulse(4); chk("R5 mode", state_code_o, 8'h08); end
        if (p >= 3) begin pulse(5); chk("R5 load", state_code_o, 8'h09); end
        if (p >= 4) begin pulse(6); chk("R5 swup", state_code_o, 8'h0A); end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 code", state_code_o, 8'h0B);
        chk("R1 rails", rails_o, 0);
        chk("R1 reset", reset_n_o, 0);
        chk("R1 snap", snap_o, 0);

        // R8: estop while off is ignored
        pulse(8);
        chk("R8 off ignore", state_code_o, 8'h0B);

        // R4 boundary, R2 start ignored while powered, R14 mid-phase snapshot
        sample_point_i = 16'd2;
        power_up();
        pulse(0);
        chk("R2 start ignored", state_code_o, 8'h06);
        pulse(2);
        chk("R14 no snap yet", snap_o, 0);
        pulse(2);
        chk("R14 snap", snap_o, 1);
        @(negedge clk);
        chk("R14 single", snap_o, 0);
        for (int b = 0; b < IDB - 1; b++) pulse(3);
        chk("R4 one short", state_code_o, 8'h06);
        pulse(3);
        chk("R4 exact", state_code_o, 8'h07);
        pulse(1);
        chk("R12 stop", state_code_o, 8'h0B);
        chk("R13 rails off", rails_o, 0);

        // R14 sample point 0 fires at reset release
        sample_point_i = 16'd0;
        snaps = 0;
        power_up();
        chk("R14 zero point", snaps, 1);
        pulse(1);

        // R14 snapshot point after run timeout; R6 run timeout
        sample_point_i = 16'd5; run_limit_i = 16'd2; indefinite_i = 0;
        snaps = 0;
        goto_phase(4);
        pulse(2);
        chk("R6 run early", state_code_o, 8'h0A);
        pulse(2);
        chk("R6 run timeout", state_code_o, 8'h11);
        chk("R14 none", snaps, 0);
        chk("R13 reset low", reset_n_o, 0);

        // R7 indefinite run
        sample_point_i = 16'd200; run_limit_i = 16'd1; indefinite_i = 1;
        goto_phase(4);
        indefinite_i = 0;
        repeat (5) pulse(2);
        chk("R7 indefinite", state_code_o, 8'h0A);
        pulse(1);

        // R10 parity beats overflow
        goto_phase(3);
        pulse(12);
        chk("R10 priority", state_code_o, 8'h15);

        // R9 dropout held blocks start
        dropout_i = 1;
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R9 held", state_code_o, 8'h14);
        dropout_i = 0;
        @(negedge clk);
        chk("R9 stays", state_code_o, 8'h14);

        // random phase x event
        sample_point_i = 16'd200;
        for (int it = 0; it < 40; it++) begin
            int p, kind, rl;
            bit ind;
            logic [7:0] e;
            p    = $urandom % 5;
            kind = $urandom % 8;
            ind  = 1'($urandom % 2);
            rl   = 1 + $urandom % 3;
            run_limit_i = 16'(rl); indefinite_i = ind;
            goto_phase(p);
            indefinite_i = 0;
            e = exp_code(p, kind, ind);
            case (kind)
                0: repeat (lim_of(p, rl)) pulse(2);
                1: pulse(8);
                2: pulse(9);
                3: pulse(10);
                4: pulse(3);
                5: pulse(1);
                6: pulse(11);
                default: begin
                    case (p)
                        0: for (int b = 0; b < IDB; b++) pulse(3);
                        1: pulse(4);
                        2: pulse(5);
                        3: pulse(6);
                        default: pulse(7);
                    endcase
                end
            endcase
            case (kind)
                0: chk(ind && p == 4 ? "R7 rand" : "R6 rand", state_code_o, e);
                1: chk("R8 rand", state_code_o, e);
                2, 3: chk("R10 rand", state_code_o, e);
                4: chk("R11 rand", state_code_o, e);
                5: chk("R12 rand", state_code_o, e);
                6: chk("R9 rand", state_code_o, e);
                default: chk("R5 rand", state_code_o, e);
            endcase
            if (state_code_o >= 8'h0B)
                chk("R13 rand", {rails_o, reset_n_o}, 0);
            else begin
                pulse(1);
                chk("R12 rand stop", state_code_o, 8'h0B);
            end
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule